// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block derives the 16x oversampling tick for a UART from a fast reference clock. A bit period is cut into 16 sub-ticks. Each sub-tick lasts a base number of reference clocks taken from an integer divisor register. A 16-bit slot pattern register marks which sub-ticks are one reference clock longer. The fractional part of the division is thus spread over the bit period in a pattern chosen by software, instead of being accumulated at one point.

Software writes the divisor as (reference clock / baud) / 16 − 1. It then writes a slot pattern that has as many set bits as the remainder modulo 16, with those bits spread evenly. Writes go through a small register port and take effect only at a bit-period boundary. An enable input starts and stops the generator. The outputs are a one-cycle tick at the end of every sub-tick and a bit strobe that coincides with every sixteenth tick.

Top module: `frac_baud_tick_gen`

## Requirements
- R1: After reset, and before enable is first raised, `tick_o` and `bit_stb_o` are low.
- R2: The distance in reference clocks between consecutive bit strobes, and from the enable edge to the first strobe, is (div+1)·16 plus the number of set bits in the slot register. An all-zero slot gives a purely integer period.
- R3: Sub-tick i (i = 0..15, with i = 0 the first sub-tick after a strobe or after enable) lasts div+1 reference clocks, plus one when bit i of the slot register is set. The tick ending sub-tick i is registered at the last edge of that sub-tick.
- R4: `tick_o` is high for one clock per sub-tick end. `bit_stb_o` is high only together with the tick that ends sub-tick 15.
- R5: A register write while enabled does not alter the period in progress. The new value applies from the next bit-period boundary.
- R6: While `en_i` is low, no tick or strobe is issued and both counters hold at zero. Raising `en_i` starts a fresh period at sub-tick 0, so the first tick follows after div+1+slot[0] clocks.
- R7: A divisor value of 0 is legal and gives sub-ticks of one clock, or two clocks when the slot bit is set.
- R8: A write with `cfg_we_i` high and `cfg_sel_i` = 0 loads the divisor from the low DIV_W bits of `cfg_wdata_i`. With `cfg_sel_i` = 1 it loads the slot pattern from the low 16 bits. Values written while disabled apply as soon as enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 divisor, 1 slot pattern |
| cfg_wdata_i | input | WR_W (16) | Write data |
| en_i | input | 1 | Run enable |
| tick_o | output | 1 | Oversampling tick, one clock at each sub-tick end |
| bit_stb_o | output | 1 | Bit-period strobe, with the tick ending sub-tick 15 |

## Verification
Both outputs are registered, so the tick that ends a sub-tick of length L is seen in the cycle after the L-th rising edge of that sub-tick. The first tick after enable appears L0 edges after the edge at which enable is first sampled high. The bench counts edges from the enable edge and keeps a running sum of the expected sub-tick lengths. It samples each output on the falling edge and compares it with that sum, and it checks every strobe against the arithmetic period formula. A write issued during a period changes the expected lengths only after the next strobe, because the write lands two edges after it is driven, well before that boundary.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

  typedef enum logic {
    FBT_SEL_DIV  = 1'b0,
    FBT_SEL_SLOT = 1'b1
  } fbt_sel_e;

  // number of set bits in a pattern
  function automatic logic [31:0] fbt_ones(input logic [31:0] pat);
    logic [31:0] acc;
    acc = '0;
    for (int k = 0; k < 32; k++) acc = acc + {31'd0, pat[k]};
    return acc;
  endfunction

  // reference clocks in one bit period for a divisor and slot pattern
  function automatic logic [31:0] fbt_period_len(input logic [31:0] div,
                                                 input logic [31:0] slot,
                                                 input int unsigned nslots);
    return (div + 32'd1) * nslots + fbt_ones(slot);
  endfunction

endpackage

// File: rtl/fbt_cfg_regs.sv
module fbt_cfg_regs #(
  parameter int DIV_W  = 16,
  parameter int SLOT_N = 16,
  parameter int WR_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [WR_W-1:0]   wdata_i,
  input  logic              load_i,
  output logic [DIV_W-1:0]  act_div_o,
  output logic [SLOT_N-1:0] act_slot_o
);
  import fbt_pkg::*;

  logic [DIV_W-1:0]  shd_div_q;
  logic [SLOT_N-1:0] shd_slot_q;
  logic              wr_div, wr_slot;

  assign wr_div  = we_i && (fbt_sel_e'(sel_i) == FBT_SEL_DIV);
  assign wr_slot = we_i && (fbt_sel_e'(sel_i) == FBT_SEL_SLOT);

  // shadow copies take every write at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_div_q  <= '0;
      shd_slot_q <= '0;
    end else begin
      if (wr_div)  shd_div_q  <= wdata_i[DIV_W-1:0];
      if (wr_slot) shd_slot_q <= wdata_i[SLOT_N-1:0];
    end
  end

  // active copies change only at a period boundary or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_div_o  <= '0;
      act_slot_o <= '0;
    end else if (load_i) begin
      act_div_o  <= shd_div_q;
      act_slot_o <= shd_slot_q;
    end
  end

endmodule

// File: rtl/fbt_sub_counter.sv
module fbt_sub_counter #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             extra_i,
  output logic [DIV_W:0]   cnt_o,
  output logic             sub_done_o
);
  localparam int CNT_W = DIV_W + 1;

  // last count value of a sub-tick: div + extra (length div+1+extra)
  function automatic logic [CNT_W-1:0] last_count(input logic [DIV_W-1:0] d,
                                                  input logic e);
    return {1'b0, d} + {{(CNT_W-1){1'b0}}, e};
  endfunction

  logic [CNT_W-1:0] cnt_q;

  assign sub_done_o = en_i && (cnt_q == last_count(div_i, extra_i));
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!en_i)      cnt_q <= '0;
    else if (sub_done_o) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/fbt_slot_seq.sv
module fbt_slot_seq #(
  parameter int SLOT_N = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sub_done_i,
  input  logic [SLOT_N-1:0] slot_i,
  output logic              extra_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              period_end_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOT_N - 1);

  logic [IDX_W-1:0] idx_q;

  assign idx_o        = idx_q;
  assign extra_o      = slot_i[idx_q];
  assign period_end_o = sub_done_i && (idx_q == IDX_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           idx_q <= '0;
    else if (!en_i)        idx_q <= '0;
    else if (period_end_o) idx_q <= '0;
    else if (sub_done_i)   idx_q <= idx_q + 1'b1;
  end

endmodule

// File: rtl/frac_baud_tick_gen.sv
module frac_baud_tick_gen #(
  parameter int DIV_W  = 16,
  parameter int SLOT_N = 16,
  parameter int WR_W   = (DIV_W > SLOT_N) ? DIV_W : SLOT_N
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic            cfg_sel_i,
  input  logic [WR_W-1:0] cfg_wdata_i,
  input  logic            en_i,
  output logic            tick_o,
  output logic            bit_stb_o
);
  localparam int IDX_W = $clog2(SLOT_N);

  // named internal events, also observed by the checker
  logic [DIV_W-1:0]  act_div;
  logic [SLOT_N-1:0] act_slot;
  logic [DIV_W:0]    cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              extra_bit;
  logic              sub_done;
  logic              period_end;
  logic              cfg_load;

  assign cfg_load = !en_i || period_end;

  fbt_cfg_regs #(.DIV_W(DIV_W), .SLOT_N(SLOT_N), .WR_W(WR_W)) cfg_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sel_i     (cfg_sel_i),
    .wdata_i   (cfg_wdata_i),
    .load_i    (cfg_load),
    .act_div_o (act_div),
    .act_slot_o(act_slot)
  );

  fbt_sub_counter #(.DIV_W(DIV_W)) sub_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .div_i     (act_div),
    .extra_i   (extra_bit),
    .cnt_o     (cnt_q),
    .sub_done_o(sub_done)
  );

  fbt_slot_seq #(.SLOT_N(SLOT_N), .IDX_W(IDX_W)) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .sub_done_i  (sub_done),
    .slot_i      (act_slot),
    .extra_o     (extra_bit),
    .idx_o       (idx_q),
    .period_end_o(period_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_o    <= 1'b0;
      bit_stb_o <= 1'b0;
    end else begin
      tick_o    <= sub_done;
      bit_stb_o <= period_end;
    end
  end

endmodule

// File: rtl/fbt_checker.sv
module fbt_checker #(
  parameter int DIV_W  = 16,
  parameter int SLOT_N = 16,
  parameter int IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              tick_o,
  input logic              bit_stb_o,
  input logic [DIV_W-1:0]  act_div,
  input logic [SLOT_N-1:0] act_slot,
  input logic [DIV_W:0]    cnt_q,
  input logic [IDX_W-1:0]  idx_q,
  input logic              extra_bit,
  input logic              sub_done,
  input logic              period_end
);
  import fbt_pkg::*;

  logic [31:0] per_cnt_q;
  logic [31:0] per_exp_q;

  // cycles since the period began, and the length its config implies
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_cnt_q <= '0;
      per_exp_q <= '0;
    end else if (!en_i) begin
      per_cnt_q <= '0;
    end else if (per_cnt_q == 32'd0 || bit_stb_o) begin
      per_cnt_q <= 32'd1;
      per_exp_q <= fbt_period_len(32'(act_div), 32'(act_slot), SLOT_N);
    end else begin
      per_cnt_q <= per_cnt_q + 32'd1;
    end
  end

  p_period_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> per_cnt_q == per_exp_q);

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= ({1'b0, act_div} + {{DIV_W{1'b0}}, extra_bit}));

  p_idx_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sub_done && !period_end) |=> idx_q == $past(idx_q) + 1'b1);

  p_strobe_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> tick_o);

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |=> idx_q == '0 && bit_stb_o);

  p_cfg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !period_end) |=> $stable(act_div) && $stable(act_slot));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o && !bit_stb_o && cnt_q == '0 && idx_q == '0);

endmodule

bind frac_baud_tick_gen fbt_checker #(
  .DIV_W(DIV_W), .SLOT_N(SLOT_N), .IDX_W(IDX_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .tick_o    (tick_o),
  .bit_stb_o (bit_stb_o),
  .act_div   (act_div),
  .act_slot  (act_slot),
  .cnt_q     (cnt_q),
  .idx_q     (idx_q),
  .extra_bit (extra_bit),
  .sub_done  (sub_done),
  .period_end(period_end)
);

// File: tb/frac_baud_tick_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [15:0] wdata = '0;
  logic        en = 1'b0;
  logic        tick, stb;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  frac_baud_tick_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_wdata_i(wdata), .en_i(en), .tick_o(tick), .bit_stb_o(stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ones16(input int v);
    int c = 0;
    for (int k = 0; k < 16; k++) if (((v >> k) & 1) != 0) c++;
    return c;
  endfunction

  task automatic wr(input bit s, input int v);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = 16'(v);
    @(negedge clk);
    we = 1'b0;
  endtask

  // enable with (d,s); optionally write (nd,ns) at edge count chg; run some periods
  task automatic run_cfg(input int d, input int s, input int nd, input int ns,
                         input int chg, input int periods, input string tag);
    int cd = d, cs = s, idx = 0, n = 0, last = 0, strobes = 0, nxt;
    bit pend = 1'b0, exp_t;
    @(negedge clk); en = 1'b0;
    wr(1'b0, d);
    wr(1'b1, s);
    @(negedge clk);
    en = 1'b1;
    nxt = d + 1 + (s & 1);
    while (strobes < periods && n < 5000) begin
      @(negedge clk);
      n++;
      exp_t = (n == nxt);
      if (exp_t || tick || stb) begin
        check(tick == exp_t, {tag, " R3 tick timing"}, int'(tick), int'(exp_t));
        check(stb == (exp_t && idx == 15), {tag, " R4 strobe on 16th tick"},
              int'(stb), int'(exp_t && idx == 15));
      end
      if (exp_t) begin
        if (idx == 15) begin
          check(n - last == (cd + 1) * 16 + ones16(cs), {tag, " R2 period"},
                n - last, (cd + 1) * 16 + ones16(cs));
          strobes++;
          last = n;
          idx = 0;
          if (pend) begin cd = nd; cs = ns; pend = 1'b0; end
        end else idx++;
        nxt = n + cd + 1 + ((cs >> idx) & 1);
      end
      // mid-period write (R5): takes effect after the next strobe
      if (n == chg) begin we = 1'b1; sel = 1'b0; wdata = 16'(nd); pend = 1'b1; end
      if (n == chg + 1) begin sel = 1'b1; wdata = 16'(ns); end
      if (n == chg + 2) we = 1'b0;
    end
    check(strobes == periods, {tag, " R2 strobes seen"}, strobes, periods);
    en = 1'b0;
  endtask

  initial begin
    int quiet;
    repeat (4) @(negedge clk);
    check(tick == 1'b0 && stb == 1'b0, "R1 outputs in reset", int'(tick) + int'(stb), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tick == 1'b0 && stb == 1'b0, "R1 idle after reset", int'(tick) + int'(stb), 0);

    run_cfg(0, 16'h0000, 0, 0, -10, 2, "R7 div0 integer");
    run_cfg(0, 16'h0080, 0, 0, -10, 2, "R7 div0 one slot");
    run_cfg(0, 16'hffdf, 0, 0, -10, 2, "R7 div0 fifteen");
    run_cfg(1, 16'h0808, 0, 0, -10, 2, "R8 div1 two");
    run_cfg(2, 16'h2222, 0, 0, -10, 2, "R3 div2 four");
    run_cfg(3, 16'h5555, 0, 0, -10, 2, "R3 div3 eight");
    run_cfg(4, 16'h4924, 0, 0, -10, 2, "R3 div4 five");
    run_cfg(5, 16'hffff, 0, 0, -10, 2, "R2 div5 full");
    run_cfg(6, 16'h0001, 0, 0, -10, 2, "R3 div6 bit0");
    run_cfg(2, 16'h0808, 1, 16'h5555, 10, 3, "R5 mid write");
    run_cfg(3, 16'h0000, 0, 16'hdfdd, 30, 3, "R5 mid write 2");

    // R6: disable mid-period, expect silence, then a fresh start
    @(negedge clk); en = 1'b1;
    repeat (30) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    quiet = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tick || stb) quiet++;
    end
    check(quiet == 0, "R6 no ticks while disabled", quiet, 0);
    run_cfg(1, 16'h0080, 0, 0, -10, 1, "R6 fresh start");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule